// File: doc/BRIEF.md
# Dual Leaky Bucket Traffic Policer

This block meters a stream of frames against two leaky buckets. A peak bucket is always active, and a committed bucket can be switched on as well. Accepted traffic fills each bucket. On every drain tick, each bucket empties by its configured rate. A bucket passes a frame while its fill level is at or below its burst threshold. This overshoot rule lets the admitted frame carry the level past the threshold.

The configuration word sets four things:
- the charging mode: bytes including the inter-packet gap, bytes excluding it, or a fixed cost per frame at one of two scales;
- whether committed drain that goes unused is passed on to the peak bucket;
- whether the committed bucket is enabled;
- a rate and a burst for each bucket.

Each frame arrives as a start strobe with its length and a valid qualifier. One cycle later the block returns a verdict. Both fill levels can be overwritten. Writing all ones to the peak bucket makes it look full, so every later frame is dropped until it drains.

Top module: `dlb_policer`

## Requirements
- R1: After reset both fill levels are 0 and `verdict_vld` is 0.
- R2: A start strobe with `frm_valid` low, or `frm_valid` without a strobe, produces no verdict and leaves both levels unchanged.
- R3: The charge per frame depends on `cfg_mode`. Mode 0 charges length plus `cfg_ipg`. Mode 1 charges length only. Mode 2 charges the fixed amount HI_INC (default 125). Mode 3 charges LO_INC (default 13653).
- R4: The peak threshold is `cfg_pir_burst` shifted left by 12. A frame whose peak level is at or below the threshold is admitted, even if it then exceeds the threshold. A frame above the threshold is discarded, and neither bucket is charged.
- R5: With `cfg_cir_ena` set, an admitted frame within the committed threshold (`cfg_cir_burst` shifted left by 12) is conforming and charges only the committed bucket. An admitted frame beyond that threshold is excess and charges only the peak bucket.
- R6: With `cfg_cir_ena` clear, every admitted frame is conforming and charges the peak bucket.
- R7: A drain tick subtracts the bucket's rate from each level, saturating at 0. A frame charged in the same cycle adds on top of the drained level.
- R8: With both `cfg_couple` and `cfg_cir_ena` set, a tick that finds the committed level below its rate adds the unused part (rate minus level) to the peak bucket's drain. Otherwise the peak bucket drains by its own rate only.
- R9: A state write loads `st_wdata` into the selected level on the next cycle and overrides a tick or charge in the same cycle. A peak level of all ones discards every frame.
- R10: A peak rate of 65535 with burst 0 makes policing transparent. A frame into an empty bucket conforms, and one tick empties the bucket again.
- R11: `verdict_vld` pulses in the cycle after each qualified strobe. The `verdict` encoding is 0 conforming, 1 excess, 2 discard. Value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Charging mode 0..3 |
| cfg_ipg | input | 5 | Gap bytes added in mode 0 |
| cfg_couple | input | 1 | Pass unused committed drain to peak bucket |
| cfg_cir_ena | input | 1 | Enable committed bucket |
| cfg_pir_rate | input | 16 | Peak drain per tick |
| cfg_pir_burst | input | 7 | Peak threshold in 4096 units |
| cfg_cir_rate | input | 16 | Committed drain per tick |
| cfg_cir_burst | input | 7 | Committed threshold in 4096 units |
| drain_tick | input | 1 | Periodic drain strobe |
| st_wr_pir | input | 1 | Overwrite peak level |
| st_wr_cir | input | 1 | Overwrite committed level |
| st_wdata | input | 23 | Level to write |
| frm_start | input | 1 | Frame start strobe |
| frm_len | input | 14 | Frame length in bytes |
| frm_valid | input | 1 | Frame is mapped to this policer |
| verdict_vld | output | 1 | Verdict valid |
| verdict | output | 2 | 0 conform, 1 excess, 2 discard |
| pir_level | output | 23 | Peak fill level |
| cir_level | output | 23 | Committed fill level |

## Verification
Each of the four modes is tried with the same 100-byte frame. The resulting charges (120, 100, 125, 13653) show that the gap is added only in line mode and that length is ignored in the frame modes. The preloaded levels straddle the thresholds: exactly at the threshold, the frame is admitted and overshoots; one frame later, it is discarded with no charge. This separates an inclusive comparison from a strict one and confirms that dropped traffic is not charged. Drain tests preload a level that is not a multiple of the rate, which exposes the saturation at zero. The same tick is then run with coupling on and off, so the borrowed committed drain shows up as a 300-unit difference. An all-ones write and the maximum-rate, zero-burst setting cover the two extreme configurations.

// File: rtl/dlb_policer.sv
module dlb_policer #(
  parameter int RATE_W   = 16,
  parameter int BURST_W  = 7,
  parameter int LVL_W    = 23,
  parameter int IPG_W    = 5,
  parameter int LEN_W    = 14,
  parameter int BURST_SH = 12,
  parameter int HI_INC   = 125,
  parameter int LO_INC   = 13653
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_mode,
  input  logic [IPG_W-1:0]   cfg_ipg,
  input  logic               cfg_couple,
  input  logic               cfg_cir_ena,
  input  logic [RATE_W-1:0]  cfg_pir_rate,
  input  logic [BURST_W-1:0] cfg_pir_burst,
  input  logic [RATE_W-1:0]  cfg_cir_rate,
  input  logic [BURST_W-1:0] cfg_cir_burst,
  input  logic               drain_tick,
  input  logic               st_wr_pir,
  input  logic               st_wr_cir,
  input  logic [LVL_W-1:0]   st_wdata,
  input  logic               frm_start,
  input  logic [LEN_W-1:0]   frm_len,
  input  logic               frm_valid,
  output logic               verdict_vld,
  output logic [1:0]         verdict,
  output logic [LVL_W-1:0]   pir_level,
  output logic [LVL_W-1:0]   cir_level
);
  localparam int XW = LVL_W + 1;
  localparam logic [1:0] V_OK = 2'd0, V_EXC = 2'd1, V_DROP = 2'd2;

  function automatic logic [LVL_W-1:0] step(input logic [LVL_W-1:0] lvl,
                                            input logic [XW-1:0] drain,
                                            input logic [LVL_W-1:0] add);
    logic [XW-1:0] drained, sum;
    drained = ({1'b0, lvl} > drain) ? {1'b0, lvl} - drain : '0;
    sum     = drained + {1'b0, add};
    return sum[LVL_W] ? '1 : sum[LVL_W-1:0];
  endfunction

  logic             frame, pir_ok, cir_ok, cir_hit, pir_hit;
  logic [LVL_W-1:0] charge, pir_thr, cir_thr;
  logic [XW-1:0]    cir_spare, pir_drain, cir_drain;

  assign frame   = frm_start & frm_valid;
  assign pir_thr = LVL_W'(cfg_pir_burst) << BURST_SH;
  assign cir_thr = LVL_W'(cfg_cir_burst) << BURST_SH;
  assign pir_ok  = pir_level <= pir_thr;
  assign cir_ok  = cir_level <= cir_thr;
  assign cir_hit = frame & pir_ok & cfg_cir_ena & cir_ok;
  assign pir_hit = frame & pir_ok & ~(cfg_cir_ena & cir_ok);

  always_comb begin
    case (cfg_mode)
      2'd0:    charge = LVL_W'(frm_len) + LVL_W'(cfg_ipg);
      2'd1:    charge = LVL_W'(frm_len);
      2'd2:    charge = LVL_W'(HI_INC);
      default: charge = LVL_W'(LO_INC);
    endcase
  end

  assign cir_spare = (cfg_couple && cfg_cir_ena && (XW'(cir_level) < XW'(cfg_cir_rate)))
                     ? XW'(cfg_cir_rate) - XW'(cir_level) : '0;
  assign cir_drain = drain_tick ? XW'(cfg_cir_rate) : '0;
  assign pir_drain = drain_tick ? XW'(cfg_pir_rate) + cir_spare : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pir_level   <= '0;
      cir_level   <= '0;
      verdict_vld <= 1'b0;
      verdict     <= V_OK;
    end else begin
      pir_level   <= st_wr_pir ? st_wdata : step(pir_level, pir_drain, pir_hit ? charge : '0);
      cir_level   <= st_wr_cir ? st_wdata : step(cir_level, cir_drain, cir_hit ? charge : '0);
      verdict_vld <= frame;
      if (frame)
        verdict <= !pir_ok ? V_DROP : ((cfg_cir_ena && !cir_ok) ? V_EXC : V_OK);
    end
  end

  a_r2_no_frame_no_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_start && frm_valid) |=> !verdict_vld);

  a_r4_drop_uncharged: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && frm_valid && !drain_tick && !st_wr_pir && !st_wr_cir && pir_level > pir_thr)
    |=> (verdict == V_DROP) && $stable(pir_level) && $stable(cir_level));

  a_r7_drain_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_tick && !frm_start && !st_wr_pir && pir_level <= LVL_W'(cfg_pir_rate))
    |=> pir_level == '0);

  a_r9_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_pir |=> pir_level == $past(st_wdata));

  a_r11_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |-> verdict != 2'd3);
endmodule

// File: tb/test_dlb_policer.sv
module test_dlb_policer;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_mode = 1;
  logic [4:0] cfg_ipg = 20;
  logic cfg_couple = 0, cfg_cir_ena = 0;
  logic [15:0] cfg_pir_rate = 0, cfg_cir_rate = 0;
  logic [6:0] cfg_pir_burst = 127, cfg_cir_burst = 127;
  logic drain_tick = 0, st_wr_pir = 0, st_wr_cir = 0;
  logic [22:0] st_wdata = 0;
  logic frm_start = 0, frm_valid = 0;
  logic [13:0] frm_len = 0;
  logic verdict_vld;
  logic [1:0] verdict;
  logic [22:0] pir_level, cir_level;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dlb_policer i_dlb_policer (.*);

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic p, input logic c, input int val);
    @(negedge clk); st_wr_pir = p; st_wr_cir = c; st_wdata = 23'(val);
    @(negedge clk); st_wr_pir = 0; st_wr_cir = 0;
  endtask

  task automatic tick();
    @(negedge clk); drain_tick = 1;
    @(negedge clk); drain_tick = 0;
  endtask

  task automatic send(input int len, input logic start, input logic vld);
    @(negedge clk); frm_start = start; frm_valid = vld; frm_len = 14'(len);
    @(negedge clk); frm_start = 0; frm_valid = 0;
  endtask

  task automatic t_reset();
    check("R1 pir", pir_level, 0); check("R1 cir", cir_level, 0);
    check("R1 vld", verdict_vld, 0);
  endtask

  task automatic t_modes();
    cfg_cir_ena = 0; cfg_pir_burst = 127;
    cfg_mode = 0; wr(1, 0, 0); send(100, 1, 1);
    check("R3 line", pir_level, 120); check("R6 conform", verdict, 0);
    check("R11 vld", verdict_vld, 1);
    cfg_mode = 1; wr(1, 0, 0); send(100, 1, 1); check("R3 data", pir_level, 100);
    cfg_mode = 2; wr(1, 0, 0); send(100, 1, 1); check("R3 hi", pir_level, 125);
    cfg_mode = 3; wr(1, 0, 0); send(100, 1, 1); check("R3 lo", pir_level, 13653);
    cfg_mode = 1;
  endtask

  task automatic t_overshoot();
    cfg_pir_burst = 1; wr(1, 0, 4096);
    send(1000, 1, 1); check("R4 at thr", verdict, 0); check("R4 overshoot", pir_level, 5096);
    send(1000, 1, 1); check("R4 drop", verdict, 2); check("R4 no charge", pir_level, 5096);
    cfg_pir_burst = 127;
  endtask

  task automatic t_committed();
    cfg_cir_ena = 1; cfg_cir_burst = 1; wr(1, 1, 0); wr(0, 1, 4096);
    send(100, 1, 1); check("R5 conform", verdict, 0);
    check("R5 cir chg", cir_level, 4196); check("R5 pir kept", pir_level, 0);
    send(100, 1, 1); check("R5 excess", verdict, 1);
    check("R5 pir chg", pir_level, 100); check("R5 cir kept", cir_level, 4196);
    cfg_cir_ena = 0; cfg_cir_burst = 127;
  endtask

  task automatic t_ignored();
    wr(1, 1, 50);
    send(300, 1, 0); check("R2 no vld", verdict_vld, 0); check("R2 pir", pir_level, 50);
    send(300, 0, 1); check("R2 no vld2", verdict_vld, 0); check("R2 cir", cir_level, 50);
  endtask

  task automatic t_drain();
    cfg_pir_rate = 300; wr(1, 0, 1000);
    tick(); check("R7 drain", pir_level, 700);
    tick(); tick(); tick(); check("R7 floor", pir_level, 0);
    wr(1, 0, 1000);
    @(negedge clk); drain_tick = 1; frm_start = 1; frm_valid = 1; frm_len = 100;
    @(negedge clk); drain_tick = 0; frm_start = 0; frm_valid = 0;
    check("R7 tick+frame", pir_level, 800);
  endtask

  task automatic t_couple();
    cfg_cir_ena = 1; cfg_cir_rate = 500; cfg_pir_rate = 100; cfg_couple = 1;
    wr(1, 0, 1000); wr(0, 1, 200); tick();
    check("R8 coupled pir", pir_level, 600); check("R8 cir", cir_level, 0);
    cfg_couple = 0; wr(1, 0, 1000); wr(0, 1, 200); tick();
    check("R8 uncoupled pir", pir_level, 900);
    cfg_cir_ena = 0; cfg_pir_rate = 0; cfg_cir_rate = 0;
  endtask

  task automatic t_full();
    wr(1, 0, 23'h7FFFFF); send(64, 1, 1); check("R9 full drop", verdict, 2);
    cfg_cir_ena = 1; wr(0, 1, 0); send(64, 1, 1); check("R9 full drop cir", verdict, 2);
    cfg_cir_ena = 0;
    @(negedge clk); st_wr_pir = 1; st_wdata = 77; frm_start = 1; frm_valid = 1; frm_len = 500;
    @(negedge clk); st_wr_pir = 0; frm_start = 0; frm_valid = 0;
    check("R9 write priority", pir_level, 77);
  endtask

  task automatic t_disable();
    cfg_pir_rate = 16'hFFFF; cfg_pir_burst = 0; wr(1, 0, 0);
    send(1500, 1, 1); check("R10 pass", verdict, 0); check("R10 lvl", pir_level, 1500);
    tick(); check("R10 empty", pir_level, 0);
    send(1500, 1, 1); check("R10 pass2", verdict, 0);
    cfg_pir_rate = 0; cfg_pir_burst = 127;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_modes(); t_overshoot(); t_committed(); t_ignored();
    t_drain(); t_couple(); t_full(); t_disable();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule